// File: doc/BRIEF.md
# Split Dual-Half Issue Queue

This block is the issue stage of a wide out-of-order core. It holds dispatched operations until their source operands are available and then hands them to execution ports. The main scheduler is built as two identical halves, and each half feeds its own private group of four ports: load/store, integer, load and vector. Two small side queues sit beside the halves, one for branch operations and one for condition-register operations. Each side queue issues at most one operation per cycle. Together the two halves can issue up to eight operations per cycle, so the whole stage issues at most ten.

Dispatch delivers one operation per cycle. The operation's class picks the queue. For the main queue, the SMT mode and the thread number pick the half. In single-thread mode both halves serve the one thread, and dispatch balances their occupancy. In the multi-thread modes a thread is bound to one half, so threads on the other half can never fill or block its entries. Source readiness arrives on a wakeup tag bus. A per-thread flush input removes all of a thread's entries in one cycle. The SMT mode may only be changed while every queue is empty.

Top module: `iq_split_issue`

## Requirements
- R1: In single-thread mode (smt_mode 0), an accepted main-class operation goes to the half with more free entries. On a tie it goes to the half opposite to the one used by the previous single-thread main dispatch. After reset that previous half counts as half 1, so the first tie picks half 0.
- R2: Each main half holds 32 entries. After reset, single-thread mode accepts 64 operations that are not ready, and it rejects the 65th (disp_accept low).
- R3: In 2-way mode (smt_mode 1), a main-class operation of thread t goes to half t[0]. Filling one half with one thread's 32 entries rejects that thread's further operations, but operations of the other thread are still accepted.
- R4: In 4-way (smt_mode 2) and 8-way (smt_mode 3) modes, all threads with the same t[0] share half t[0] and its 32 entries.
- R5: The kind field selects the port inside a half: 0 load/store, 1 integer, 2 load, 3 vector. Main issue port index is half*4+kind. Each port issues at most one operation per cycle, and all eight ports may issue in the same cycle.
- R6: When several ready operations in one half compete for one port, the one dispatched earliest issues first.
- R7: A source becomes ready at the clock edge where its tag appears on an active wakeup lane. This includes a tag that matches in the same cycle as dispatch. A tag that does not match has no effect. An operation whose sources are all ready is driven on its issue port in the cycle after the edge that made it ready or accepted it, and it leaves the queue at the next edge.
- R8: Class 1 operations go to the branch queue. The branch queue holds 8 entries, issues at most one per cycle, and issues in dispatch order among ready entries.
- R9: Class 2 operations go to the condition-register queue. It has the same depth, the same one-per-cycle limit and the same ordering as the branch queue.
- R10: While flush_mask bit t is high, no queue issues an operation of thread t and a dispatch of thread t is rejected. At that clock edge, every entry of thread t in every queue is removed.
- R11: Every issue port carries the destination tag and the thread of the operation it issues. After reset no issue valid is high, and an operation of class 3 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smt_mode | input | 2 | 0 single thread, 1 two-way, 2 four-way, 3 eight-way |
| disp_vld | input | 1 | Dispatch request |
| disp_cls | input | 2 | 0 main, 1 branch, 2 condition register |
| disp_kind | input | 2 | Main port kind: 0 load/store, 1 integer, 2 load, 3 vector |
| disp_tid | input | 3 | Thread of the operation |
| disp_dst | input | 6 | Destination tag |
| disp_src | input | 12 | Two source tags, source 0 in the low bits |
| disp_src_rdy | input | 2 | Source already available at dispatch |
| disp_accept | output | 1 | Operation taken at this edge |
| wake_vld | input | 2 | Wakeup lane valid |
| wake_tag | input | 12 | Wakeup tags, lane 0 in the low bits |
| flush_mask | input | 8 | One bit per thread to discard |
| main_iss_vld | output | 8 | Main port valid, index half*4+kind |
| main_iss_dst | output | 48 | Destination tag per main port |
| main_iss_tid | output | 24 | Thread per main port |
| br_iss_vld | output | 1 | Branch issue valid |
| br_iss_dst | output | 6 | Branch destination tag |
| br_iss_tid | output | 3 | Branch thread |
| cr_iss_vld | output | 1 | Condition-register issue valid |
| cr_iss_dst | output | 6 | Condition-register destination tag |
| cr_iss_tid | output | 3 | Condition-register thread |

## Verification
One test separates balancing by free count from plain alternation. It flushes one thread so that the half used last becomes the emptier one. A steering unit that only alternated would pick the wrong half, and its issue would appear on the wrong port. Capacity tests fill single halves, mixed thread pairs and the side queues to the last entry. A half that leaked entries between threads, or that was shared in 2-way mode, would accept the 33rd operation or reject the other thread. Out-of-order wakeups check that the older operation wins its port. A wakeup that arrives in the same cycle as dispatch must not be lost. Flush is checked both in its own cycle, where issue of the flushed thread must be held back while other threads still issue, and after it, where a flushed entry that was ready must never reappear.

// File: rtl/iq_pkg.sv
package iq_pkg;
    parameter int TAG_W = 6;
    parameter int TID_W = 3;
    parameter int NSRC  = 2;
    parameter int NKIND = 4;
    localparam int NTHR   = 1 << TID_W;
    localparam int KIND_W = $clog2(NKIND);

    typedef enum logic [1:0] {
        CLS_MAIN = 2'd0,
        CLS_BR   = 2'd1,
        CLS_CR   = 2'd2
    } op_cls_e;

    typedef enum logic [1:0] {
        MODE_ST   = 2'd0,
        MODE_SMT2 = 2'd1,
        MODE_SMT4 = 2'd2,
        MODE_SMT8 = 2'd3
    } smt_mode_e;

    typedef struct packed {
        logic [KIND_W-1:0]            kind;
        logic [TID_W-1:0]             tid;
        logic [TAG_W-1:0]             dst;
        logic [NSRC-1:0][TAG_W-1:0]   src;
        logic [NSRC-1:0]              rdy;
    } iq_op_t;
endpackage

// File: rtl/iq_slice.sv
module iq_slice import iq_pkg::*; #(
    parameter int DEPTH  = 32,
    parameter int PORTS  = 4,
    parameter int WAKE_N = 2,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_vld,
    input  iq_op_t                   alloc_op,
    input  logic [WAKE_N-1:0]        wake_vld,
    input  logic [WAKE_N*TAG_W-1:0]  wake_tag,
    input  logic [NTHR-1:0]          flush,
    output logic [CNT_W-1:0]         free_cnt,
    output logic [PORTS-1:0]         iss_vld,
    output logic [PORTS*TAG_W-1:0]   iss_dst,
    output logic [PORTS*TID_W-1:0]   iss_tid
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // older[i][j] set: entry j was dispatched before entry i
    typedef struct packed {
        logic [DEPTH-1:0]              vld;
        iq_op_t [DEPTH-1:0]            ent;
        logic [DEPTH-1:0][DEPTH-1:0]   older;
    } slice_st_t;

    slice_st_t st_q, st_d;
    logic [PORTS-1:0][DEPTH-1:0] req, win;
    logic [DEPTH-1:0]            gone;
    logic [IDX_W-1:0]            free_idx;
    logic                        has_free;
    logic [NTHR-1:0][DEPTH-1:0]  thr_live;

    function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                     input logic [WAKE_N-1:0] wv,
                                     input logic [WAKE_N*TAG_W-1:0] wt);
        logic h;
        h = 1'b0;
        for (int w = 0; w < WAKE_N; w++) begin
            if (wv[w] && (wt[w*TAG_W +: TAG_W] == t)) h = 1'b1;
        end
        return h;
    endfunction

    // request and oldest-first pick per port
    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                req[p][i] = st_q.vld[i] && (&st_q.ent[i].rdy)
                          && !flush[st_q.ent[i].tid]
                          && ((PORTS == 1) || (int'(st_q.ent[i].kind) == p));
            end
        end
        for (int p = 0; p < PORTS; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                win[p][i] = req[p][i] && !(|(req[p] & st_q.older[i]));
            end
        end
    end

    always_comb begin
        iss_vld = '0;
        iss_dst = '0;
        iss_tid = '0;
        for (int p = 0; p < PORTS; p++) begin
            iss_vld[p] = |win[p];
            for (int i = 0; i < DEPTH; i++) begin
                if (win[p][i]) begin
                    iss_dst[p*TAG_W +: TAG_W] = st_q.ent[i].dst;
                    iss_tid[p*TID_W +: TID_W] = st_q.ent[i].tid;
                end
            end
        end
    end

    always_comb begin
        free_cnt = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            free_cnt = free_cnt + CNT_W'(!st_q.vld[i]);
        end
    end

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            for (int i = 0; i < DEPTH; i++) begin
                thr_live[t][i] = st_q.vld[i] && (int'(st_q.ent[i].tid) == t);
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        gone = '0;
        for (int i = 0; i < DEPTH; i++) begin
            gone[i] = flush[st_q.ent[i].tid];
            for (int p = 0; p < PORTS; p++) begin
                if (win[p][i]) gone[i] = 1'b1;
            end
            if (gone[i]) st_d.vld[i] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (tag_hit(st_q.ent[i].src[s], wake_vld, wake_tag)) st_d.ent[i].rdy[s] = 1'b1;
            end
        end
        if (alloc_vld && has_free) begin
            st_d.ent[free_idx] = alloc_op;
            for (int s = 0; s < NSRC; s++) begin
                if (tag_hit(alloc_op.src[s], wake_vld, wake_tag)) st_d.ent[free_idx].rdy[s] = 1'b1;
            end
            st_d.vld[free_idx]   = 1'b1;
            st_d.older[free_idx] = st_q.vld & ~gone;
            for (int i = 0; i < DEPTH; i++) begin
                st_d.older[i][free_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld |-> has_free);

    for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
        p_single_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(win[p]));
        p_no_flushed_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
            iss_vld[p] |-> !flush[iss_tid[p*TID_W +: TID_W]]);
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr_chk
        p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            flush[t] |=> !(|thr_live[t]));
    end
endmodule

// File: rtl/iq_split_issue.sv
module iq_split_issue import iq_pkg::*; #(
    parameter int MAIN_DEPTH = 32,
    parameter int SIDE_DEPTH = 8,
    parameter int WAKE_N     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    smt_mode,
    input  logic                          disp_vld,
    input  logic [1:0]                    disp_cls,
    input  logic [KIND_W-1:0]             disp_kind,
    input  logic [TID_W-1:0]              disp_tid,
    input  logic [TAG_W-1:0]              disp_dst,
    input  logic [NSRC*TAG_W-1:0]         disp_src,
    input  logic [NSRC-1:0]               disp_src_rdy,
    output logic                          disp_accept,
    input  logic [WAKE_N-1:0]             wake_vld,
    input  logic [WAKE_N*TAG_W-1:0]       wake_tag,
    input  logic [NTHR-1:0]               flush_mask,
    output logic [2*NKIND-1:0]            main_iss_vld,
    output logic [2*NKIND*TAG_W-1:0]      main_iss_dst,
    output logic [2*NKIND*TID_W-1:0]      main_iss_tid,
    output logic                          br_iss_vld,
    output logic [TAG_W-1:0]              br_iss_dst,
    output logic [TID_W-1:0]              br_iss_tid,
    output logic                          cr_iss_vld,
    output logic [TAG_W-1:0]              cr_iss_dst,
    output logic [TID_W-1:0]              cr_iss_tid
);
    localparam int NHALF  = 2;
    localparam int MCNT_W = $clog2(MAIN_DEPTH + 1);
    localparam int SCNT_W = $clog2(SIDE_DEPTH + 1);

    typedef struct packed {
        logic last_half;
    } steer_st_t;

    steer_st_t               steer_q, steer_d;
    iq_op_t                  op;
    logic [NHALF-1:0][MCNT_W-1:0] main_free;
    logic [SCNT_W-1:0]       br_free, cr_free;
    logic [NHALF-1:0]        half_alloc;
    logic                    pick, main_go, br_go, cr_go, flushed;

    always_comb begin
        op.kind = disp_kind;
        op.tid  = disp_tid;
        op.dst  = disp_dst;
        op.src  = disp_src;
        op.rdy  = disp_src_rdy;
    end

    always_comb begin
        steer_d = steer_q;
        flushed = flush_mask[disp_tid];
        if (smt_mode == MODE_ST) begin
            if (main_free[0] > main_free[1])      pick = 1'b0;
            else if (main_free[1] > main_free[0]) pick = 1'b1;
            else                                  pick = !steer_q.last_half;
        end else begin
            pick = disp_tid[0];
        end
        main_go = disp_vld && (disp_cls == CLS_MAIN) && !flushed && (main_free[pick] != '0);
        br_go   = disp_vld && (disp_cls == CLS_BR)   && !flushed && (br_free != '0);
        cr_go   = disp_vld && (disp_cls == CLS_CR)   && !flushed && (cr_free != '0);
        half_alloc[0] = main_go && !pick;
        half_alloc[1] = main_go && pick;
        disp_accept   = main_go || br_go || cr_go;
        if (main_go && (smt_mode == MODE_ST)) steer_d.last_half = pick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) steer_q <= '{last_half: 1'b1};
        else        steer_q <= steer_d;
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        iq_slice #(.DEPTH(MAIN_DEPTH), .PORTS(NKIND), .WAKE_N(WAKE_N)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_vld(half_alloc[h]),
            .alloc_op (op),
            .wake_vld (wake_vld),
            .wake_tag (wake_tag),
            .flush    (flush_mask),
            .free_cnt (main_free[h]),
            .iss_vld  (main_iss_vld[h*NKIND +: NKIND]),
            .iss_dst  (main_iss_dst[h*NKIND*TAG_W +: NKIND*TAG_W]),
            .iss_tid  (main_iss_tid[h*NKIND*TID_W +: NKIND*TID_W])
        );
    end

    iq_slice #(.DEPTH(SIDE_DEPTH), .PORTS(1), .WAKE_N(WAKE_N)) u_br (
        .clk(clk), .rst_n(rst_n), .alloc_vld(br_go), .alloc_op(op),
        .wake_vld(wake_vld), .wake_tag(wake_tag), .flush(flush_mask),
        .free_cnt(br_free), .iss_vld(br_iss_vld), .iss_dst(br_iss_dst), .iss_tid(br_iss_tid)
    );

    iq_slice #(.DEPTH(SIDE_DEPTH), .PORTS(1), .WAKE_N(WAKE_N)) u_cr (
        .clk(clk), .rst_n(rst_n), .alloc_vld(cr_go), .alloc_op(op),
        .wake_vld(wake_vld), .wake_tag(wake_tag), .flush(flush_mask),
        .free_cnt(cr_free), .iss_vld(cr_iss_vld), .iss_dst(cr_iss_dst), .iss_tid(cr_iss_tid)
    );

    p_st_balance0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((smt_mode == MODE_ST) && half_alloc[0]) |-> (main_free[0] >= main_free[1]));
    p_st_balance1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((smt_mode == MODE_ST) && half_alloc[1]) |-> (main_free[1] >= main_free[0]));
    p_thread_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((smt_mode != MODE_ST) && main_go) |-> (half_alloc[1] == disp_tid[0]));
    p_flush_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld && flush_mask[disp_tid]) |-> !disp_accept);
endmodule

// File: tb/test_iq_split_issue.sv
module test_iq_split_issue;
    import iq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]               smt_mode = 2'd0;
    logic                     disp_vld = 1'b0;
    logic [1:0]               disp_cls = 2'd0;
    logic [KIND_W-1:0]        disp_kind = '0;
    logic [TID_W-1:0]         disp_tid = '0;
    logic [TAG_W-1:0]         disp_dst = '0;
    logic [NSRC*TAG_W-1:0]    disp_src = '0;
    logic [NSRC-1:0]          disp_src_rdy = '0;
    logic                     disp_accept;
    logic [1:0]               wake_vld = '0;
    logic [2*TAG_W-1:0]       wake_tag = '0;
    logic [NTHR-1:0]          flush_mask = '0;
    logic [7:0]               main_iss_vld;
    logic [8*TAG_W-1:0]       main_iss_dst;
    logic [8*TID_W-1:0]       main_iss_tid;
    logic                     br_iss_vld, cr_iss_vld;
    logic [TAG_W-1:0]         br_iss_dst, cr_iss_dst;
    logic [TID_W-1:0]         br_iss_tid, cr_iss_tid;

    iq_split_issue #(.MAIN_DEPTH(32), .SIDE_DEPTH(8), .WAKE_N(2)) i_iq_split_issue (
        .clk(clk), .rst_n(rst_n), .smt_mode(smt_mode),
        .disp_vld(disp_vld), .disp_cls(disp_cls), .disp_kind(disp_kind), .disp_tid(disp_tid),
        .disp_dst(disp_dst), .disp_src(disp_src), .disp_src_rdy(disp_src_rdy),
        .disp_accept(disp_accept), .wake_vld(wake_vld), .wake_tag(wake_tag),
        .flush_mask(flush_mask), .main_iss_vld(main_iss_vld), .main_iss_dst(main_iss_dst),
        .main_iss_tid(main_iss_tid), .br_iss_vld(br_iss_vld), .br_iss_dst(br_iss_dst),
        .br_iss_tid(br_iss_tid), .cr_iss_vld(cr_iss_vld), .cr_iss_dst(cr_iss_dst),
        .cr_iss_tid(cr_iss_tid)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int mdst(input int p);
        return int'(main_iss_dst[p*TAG_W +: TAG_W]);
    endfunction

    function automatic int mtid(input int p);
        return int'(main_iss_tid[p*TID_W +: TID_W]);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic disp(input int cls, input int kind, input int tid, input int dst,
                        input int s0, input logic [1:0] rdy, output bit acc);
        disp_vld     = 1'b1;
        disp_cls     = 2'(cls);
        disp_kind    = KIND_W'(kind);
        disp_tid     = TID_W'(tid);
        disp_dst     = TAG_W'(dst);
        disp_src     = {TAG_W'(0), TAG_W'(s0)};
        disp_src_rdy = rdy;
        #1;
        acc = disp_accept;
        @(posedge clk);
        #1;
        disp_vld = 1'b0;
    endtask

    task automatic wake(input int t0, input int t1, input logic [1:0] m);
        wake_vld = m;
        wake_tag = {TAG_W'(t1), TAG_W'(t0)};
        @(posedge clk);
        #1;
        wake_vld = '0;
    endtask

    task automatic flushm(input logic [NTHR-1:0] m);
        flush_mask = m;
        @(posedge clk);
        #1;
        flush_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit acc;
        int a, b, cnt;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        chk("R11 reset main valid", int'(main_iss_vld), 0);
        chk("R11 reset side valid", int'({br_iss_vld, cr_iss_vld}), 0);
        chk("R11 idle accept", int'(disp_accept), 0);
        step();

        // R1 tie alternation from reset, R5 port index, R11 payload
        smt_mode = 2'd0;
        a = 1;
        for (int k = 0; k < 4; k++) begin
            disp(0, k, 0, 10 + k, 0, 2'b11, acc);
            chk("R1 accept", int'(acc), 1);
            a = 1 - a;
            #1;
            chk("R5 port select", int'(main_iss_vld), 1 << (a*4 + k));
            chk("R11 dst", mdst(a*4 + k), 10 + k);
            step();
            chk("R7 leaves after issue", int'(main_iss_vld), 0);
        end
        disp(3, 0, 0, 1, 0, 2'b11, acc);
        chk("R11 class 3 rejected", int'(acc), 0);

        // R6 oldest ready first, SMT2 thread 0 -> half 0 integer port 1
        smt_mode = 2'd1;
        for (int i = 0; i < 4; i++) disp(0, 1, 0, 20 + i, 50 + i, 2'b10, acc);
        #1;
        chk("R7 no issue before wake", int'(main_iss_vld), 0);
        wake(51, 53, 2'b11);
        #1;
        chk("R6 first pick valid", int'(main_iss_vld), 2);
        chk("R6 first pick older", mdst(1), 21);
        step();
        chk("R6 second pick", mdst(1), 23);
        step();
        chk("R6 drained", int'(main_iss_vld), 0);
        wake(52, 50, 2'b11);
        #1;
        chk("R6 third pick", mdst(1), 20);
        step();
        chk("R6 fourth pick", mdst(1), 22);
        step();

        // R5 all eight ports in one cycle
        for (int k = 0; k < 4; k++) disp(0, k, 0, 30 + k, 55, 2'b10, acc);
        for (int k = 0; k < 4; k++) disp(0, k, 1, 34 + k, 55, 2'b10, acc);
        wake(55, 0, 2'b01);
        #1;
        chk("R5 eight issue", int'(main_iss_vld), 255);
        for (int p = 0; p < 8; p++) begin
            chk("R11 port dst", mdst(p), 30 + p);
            chk("R11 port tid", mtid(p), p / 4);
        end
        step();

        // R7 wakeup in dispatch cycle, non-matching tag
        wake_vld = 2'b01;
        wake_tag = {TAG_W'(0), TAG_W'(56)};
        disp(0, 2, 0, 12, 56, 2'b10, acc);
        wake_vld = '0;
        #1;
        chk("R7 same-cycle wake", int'(main_iss_vld), 4);
        step();
        disp(0, 2, 0, 13, 57, 2'b10, acc);
        wake(58, 59, 2'b11);
        #1;
        chk("R7 mismatched tag ignored", int'(main_iss_vld), 0);
        wake(57, 0, 2'b01);
        #1;
        chk("R7 matching tag", int'(main_iss_vld), 4);
        chk("R7 matching dst", mdst(2), 13);
        step();

        // R2 capacity in single-thread mode
        smt_mode = 2'd0;
        cnt = 0;
        for (int i = 0; i < 64; i++) begin
            disp(0, 1, 0, i, 61, 2'b10, acc);
            cnt += int'(acc);
        end
        chk("R2 64 accepted", cnt, 64);
        disp(0, 1, 0, 1, 61, 2'b10, acc);
        chk("R2 65th rejected", int'(acc), 0);
        wake(61, 0, 2'b01);
        #1;
        chk("R2 both halves hold ops", int'(main_iss_vld), 8'h22);
        flush_mask = 8'h01;
        #1;
        chk("R10 issue held in flush cycle", int'(main_iss_vld), 0);
        disp(0, 1, 0, 1, 0, 2'b11, acc);
        chk("R10 dispatch rejected", int'(acc), 0);
        flush_mask = '0;
        #1;
        chk("R10 entries removed", int'(main_iss_vld), 0);

        // R3 two-way binding
        smt_mode = 2'd1;
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            disp(0, 0, 0, i, 62, 2'b10, acc);
            cnt += int'(acc);
        end
        chk("R3 32 accepted", cnt, 32);
        disp(0, 0, 0, 1, 62, 2'b10, acc);
        chk("R3 own half full", int'(acc), 0);
        disp(0, 0, 1, 1, 62, 2'b10, acc);
        chk("R3 other thread free", int'(acc), 1);
        flushm(8'h03);

        // R4 four-way and eight-way sharing
        smt_mode = 2'd2;
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            disp(0, 3, (i % 2) * 2, i, 62, 2'b10, acc);
            cnt += int'(acc);
        end
        chk("R4 shared 32", cnt, 32);
        disp(0, 3, 2, 1, 62, 2'b10, acc);
        chk("R4 thread 2 blocked", int'(acc), 0);
        disp(0, 3, 0, 1, 62, 2'b10, acc);
        chk("R4 thread 0 blocked", int'(acc), 0);
        disp(0, 3, 3, 1, 62, 2'b10, acc);
        chk("R4 thread 3 free", int'(acc), 1);
        flushm(8'hFF);
        smt_mode = 2'd3;
        for (int i = 0; i < 32; i++) disp(0, 3, 4, i, 62, 2'b10, acc);
        disp(0, 3, 6, 1, 62, 2'b10, acc);
        chk("R4 eight-way thread 6 blocked", int'(acc), 0);
        disp(0, 3, 7, 1, 62, 2'b10, acc);
        chk("R4 eight-way thread 7 free", int'(acc), 1);
        flushm(8'hFF);

        // R1 free-count balance beats alternation
        smt_mode = 2'd0;
        disp(0, 1, 1, 40, 0, 2'b11, acc);
        #1;
        chk("R1 single issue", $countones(main_iss_vld), 1);
        a = main_iss_vld[5] ? 1 : 0;
        b = 1 - a;
        step();
        disp(0, 1, 1, 42, 45, 2'b10, acc);
        disp(0, 1, 0, 43, 46, 2'b10, acc);
        disp(0, 1, 1, 44, 45, 2'b10, acc);
        disp(0, 1, 0, 45, 46, 2'b10, acc);
        flushm(8'h01);
        disp(0, 1, 2, 41, 0, 2'b11, acc);
        #1;
        chk("R1 emptier half chosen", int'(main_iss_vld), 1 << (a*4 + 1));
        step();
        wake(45, 0, 2'b01);
        #1;
        chk("R1 tie went opposite", int'(main_iss_vld), 1 << (b*4 + 1));
        chk("R1 opposite dst", mdst(b*4 + 1), 42);
        flushm(8'hFF);

        // R8 branch queue, R9 condition-register queue
        for (int c = 1; c <= 2; c++) begin
            cnt = 0;
            for (int i = 0; i < 8; i++) begin
                disp(c, 0, 0, (i < 3) ? i + 1 : 20 + i, (i < 3) ? 47 : 48, 2'b10, acc);
                cnt += int'(acc);
            end
            chk((c == 1) ? "R8 depth" : "R9 depth", cnt, 8);
            disp(c, 0, 0, 9, 48, 2'b10, acc);
            chk((c == 1) ? "R8 ninth rejected" : "R9 ninth rejected", int'(acc), 0);
            wake(47, 0, 2'b01);
            for (int j = 0; j < 3; j++) begin
                #1;
                chk((c == 1) ? "R8 one per cycle" : "R9 one per cycle",
                    int'((c == 1) ? br_iss_vld : cr_iss_vld), 1);
                chk((c == 1) ? "R8 order" : "R9 order",
                    int'((c == 1) ? br_iss_dst : cr_iss_dst), j + 1);
                step();
            end
            #1;
            chk((c == 1) ? "R8 rest waiting" : "R9 rest waiting",
                int'((c == 1) ? br_iss_vld : cr_iss_vld), 0);
            flushm(8'hFF);
        end

        // R10 flush across queues, other thread unaffected
        smt_mode = 2'd3;
        disp(1, 0, 3, 5, 49, 2'b10, acc);
        disp(2, 0, 4, 6, 49, 2'b10, acc);
        disp(0, 1, 3, 7, 49, 2'b10, acc);
        wake(49, 0, 2'b01);
        #1;
        chk("R10 branch ready before flush", int'(br_iss_vld), 1);
        flush_mask = 8'h08;
        #1;
        chk("R10 branch held", int'(br_iss_vld), 0);
        chk("R10 main held", int'(main_iss_vld), 0);
        chk("R10 other thread issues", int'(cr_iss_vld), 1);
        chk("R10 other thread dst", int'(cr_iss_dst), 6);
        chk("R10 other thread tid", int'(cr_iss_tid), 4);
        step();
        flush_mask = '0;
        #1;
        chk("R10 branch entry gone", int'(br_iss_vld), 0);
        chk("R10 main entry gone", int'(main_iss_vld), 0);
        chk("R10 cr issued once", int'(cr_iss_vld), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule